// File: doc/BRIEF.md
# Zero-Address Stack Calculator Core

This block evaluates postfix arithmetic on an internal operand stack. A host hands it one instruction at a time over a valid/ready handshake. Each instruction carries a 3-bit opcode and a word address. Only the memory-transfer opcodes use the address. One of them copies a word of the local data memory onto the stack, and the other moves the top of the stack back into memory. The four arithmetic opcodes take no operands. Each consumes the two topmost entries and leaves one result in their place, so an expression such as Z = X Y × W U × + runs as a straight sequence of instructions.

A host-side port writes and reads the data memory. It is used to load operands before a run and to collect results after it. The port works only while the block is halted or no instruction is being offered. Status outputs report an accepted instruction (busy), a halt, and a sticky error. The error covers stack underflow, stack overflow and division by zero. A faulting instruction has no effect other than setting the error.

Top module: `stack_calc_core`

## Requirements
- R1: An instruction is accepted on a rising clock edge where instr_valid and instr_ready are both high, and its effect is complete at that edge. Opcodes are 000 push, 001 pop, 010 add, 011 subtract, 100 multiply, 101 divide and 111 halt.
- R2: Push copies the memory word at instr_addr onto the top of the stack, and the depth grows by one.
- R3: Pop writes the top entry to memory at instr_addr and removes it, and the depth shrinks by one.
- R4: Add, subtract and multiply replace the two top entries with (entry below top) OP (top), computed unsigned modulo 2^16.
- R5: Divide replaces the two top entries with (entry below top) / (top), truncated. 6/3 gives 2 and 7/2 gives 3.
- R6: A push onto 8 entries, a pop from 0 entries, or an arithmetic opcode with fewer than 2 entries does not execute. It sets error, and error stays high until reset.
- R7: Divide by a zero top entry sets error and leaves the stack and memory unchanged.
- R8: An accepted halt raises halted and drops instr_ready. Both hold until reset, and offered instructions are not accepted in the meantime.
- R9: busy is high in exactly the cycle after each accepted instruction, faulting ones included.
- R10: A host write lands only while halted is high or instr_valid is low, and is ignored otherwise. In those same conditions host_rdata shows the word at host_addr combinationally. Otherwise it reads 0.
- R11: Reset empties the stack, clears all 16 memory words, and sets instr_ready=1, halted=0, error=0 and busy=0.
- R12: Opcode 110 is accepted and changes neither the stack, the memory nor the error flag.
- R13: The programs (2+3)-6/3 and X*Y+W*U run to completion and leave the expected result stored and the stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Instruction can be accepted |
| instr_op | input | 3 | Opcode |
| instr_addr | input | 4 | Memory address for push and pop |
| host_we | input | 1 | Host memory write strobe |
| host_addr | input | 4 | Host memory address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| busy | output | 1 | An instruction was accepted last cycle |
| halted | output | 1 | Halt executed |
| error | output | 1 | Sticky fault flag |

## Verification
A stack pointer that is off by one either raises error at the wrong instruction, which is visible the cycle after that instruction, or lets a later pop store a stale or wrong word. That wrong word reaches host_rdata as soon as the host reads the address back. A swapped operand order or a wrong wrap shows up in the first non-commutative or overflowing result read back. A halt or busy flag that is stuck shows on the ports within one cycle, because the bench compares every status output with its model on every clock.

// File: rtl/stkm_pkg.sv
package stkm_pkg;

    typedef enum logic [2:0] {
        OP_PUSH = 3'b000,
        OP_POP  = 3'b001,
        OP_ADD  = 3'b010,
        OP_SUB  = 3'b011,
        OP_MUL  = 3'b100,
        OP_DIV  = 3'b101,
        OP_RSV  = 3'b110,
        OP_HALT = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        SC_HOLD,
        SC_PUSH,
        SC_POP,
        SC_FOLD
    } stk_cmd_e;

    typedef enum logic [1:0] {
        AL_ADD,
        AL_SUB,
        AL_MUL,
        AL_DIV
    } alu_fn_e;

    typedef struct packed {
        logic halted;
        logic error;
        logic busy;
    } ctl_t;

endpackage

// File: rtl/stkm_stack.sv
module stkm_stack
    import stkm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_cmd_e          cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] second,
    output logic [CNT_W-1:0]  count
);

    typedef struct packed {
        logic [CNT_W-1:0]                 cnt;
        logic [DEPTH-1:0][DATA_W-1:0]     ent;
    } stk_t;

    stk_t st_d, st_q;

    // entries are read only at the top and one below it
    always_comb begin
        top    = '0;
        second = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i + 1) == st_q.cnt) top    = st_q.ent[i];
            if (CNT_W'(i + 2) == st_q.cnt) second = st_q.ent[i];
        end
    end

    assign count = st_q.cnt;

    always_comb begin
        st_d = st_q;
        case (cmd)
            SC_PUSH: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i) == st_q.cnt) st_d.ent[i] = wdata;
                end
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            SC_POP: begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
            SC_FOLD: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i + 2) == st_q.cnt) st_d.ent[i] = wdata;
                end
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/stkm_alu.sv
module stkm_alu
    import stkm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] res,
    output logic              div_zero
);

    always_comb begin
        res      = '0;
        div_zero = 1'b0;
        case (fn)
            AL_ADD: res = lhs + rhs;
            AL_SUB: res = lhs - rhs;
            AL_MUL: res = lhs * rhs;
            AL_DIV: begin
                if (rhs == '0) div_zero = 1'b1;
                else           res = lhs / rhs;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stkm_dmem.sv
module stkm_dmem #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 16,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [WORDS-1:0][DATA_W-1:0] mem_d, mem_q;

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

endmodule

// File: rtl/stack_calc_core.sv
module stack_calc_core
    import stkm_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int MEM_WORDS   = 16,
    parameter int STACK_DEPTH = 8,
    localparam int AW         = $clog2(MEM_WORDS),
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [2:0]        instr_op,
    input  logic [AW-1:0]     instr_addr,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              busy,
    output logic              halted,
    output logic              error
);

    ctl_t ctl_d, ctl_q;

    opcode_e           op;
    logic              accept;
    logic              host_ok;
    logic              fault;

    stk_cmd_e          stk_cmd;
    logic [DATA_W-1:0] stk_wdata;
    logic [DATA_W-1:0] stk_top;
    logic [DATA_W-1:0] stk_second;
    logic [CNT_W-1:0]  stk_count;
    logic              stk_full;
    logic              stk_empty;
    logic              stk_pair;

    alu_fn_e           alu_fn;
    logic [DATA_W-1:0] alu_res;
    logic              alu_div_zero;

    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rd_instr;
    logic [DATA_W-1:0] mem_rd_host;

    assign op          = opcode_e'(instr_op);
    assign instr_ready = !ctl_q.halted;
    assign accept      = instr_valid && instr_ready;
    assign host_ok     = ctl_q.halted || !instr_valid;
    assign host_rdata  = host_ok ? mem_rd_host : '0;

    assign stk_full  = (stk_count == CNT_W'(STACK_DEPTH));
    assign stk_empty = (stk_count == '0);
    assign stk_pair  = (stk_count >= CNT_W'(2));

    assign busy   = ctl_q.busy;
    assign halted = ctl_q.halted;
    assign error  = ctl_q.error;

    stkm_stack #(
        .DATA_W (DATA_W),
        .DEPTH  (STACK_DEPTH)
    ) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (stk_cmd),
        .wdata  (stk_wdata),
        .top    (stk_top),
        .second (stk_second),
        .count  (stk_count)
    );

    stkm_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .fn       (alu_fn),
        .lhs      (stk_second),
        .rhs      (stk_top),
        .res      (alu_res),
        .div_zero (alu_div_zero)
    );

    stkm_dmem #(
        .DATA_W (DATA_W),
        .WORDS  (MEM_WORDS)
    ) u_dmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (instr_addr),
        .rdata_a (mem_rd_instr),
        .raddr_b (host_addr),
        .rdata_b (mem_rd_host)
    );

    // opcode to arithmetic function
    always_comb begin
        case (op)
            OP_SUB:  alu_fn = AL_SUB;
            OP_MUL:  alu_fn = AL_MUL;
            OP_DIV:  alu_fn = AL_DIV;
            default: alu_fn = AL_ADD;
        endcase
    end

    // next-state for status, stack command and memory write port
    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.busy = accept;
        stk_cmd    = SC_HOLD;
        stk_wdata  = '0;
        mem_we     = 1'b0;
        mem_waddr  = '0;
        mem_wdata  = '0;
        fault      = 1'b0;

        // host access never overlaps an accepted instruction
        if (host_we && host_ok) begin
            mem_we    = 1'b1;
            mem_waddr = host_addr;
            mem_wdata = host_wdata;
        end

        if (accept) begin
            case (op)
                OP_PUSH: begin
                    if (stk_full) begin
                        fault = 1'b1;
                    end else begin
                        stk_cmd   = SC_PUSH;
                        stk_wdata = mem_rd_instr;
                    end
                end
                OP_POP: begin
                    if (stk_empty) begin
                        fault = 1'b1;
                    end else begin
                        stk_cmd   = SC_POP;
                        mem_we    = 1'b1;
                        mem_waddr = instr_addr;
                        mem_wdata = stk_top;
                    end
                end
                OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
                    if (!stk_pair || alu_div_zero) begin
                        fault = 1'b1;
                    end else begin
                        stk_cmd   = SC_FOLD;
                        stk_wdata = alu_res;
                    end
                end
                OP_HALT: ctl_d.halted = 1'b1;
                default: ;
            endcase
        end

        if (fault) ctl_d.error = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/stkm_chk.sv
module stkm_chk #(
    parameter int CNT_W = 4,
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic             instr_ready,
    input logic [2:0]       instr_op,
    input logic             halted,
    input logic             error,
    input logic             busy,
    input logic [CNT_W-1:0] depth
);

    logic acc;
    assign acc = instr_valid && instr_ready;

    // R8
    halt_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !instr_ready);

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R6
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);

    // R9
    busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !busy);

    // R2
    push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && instr_op == 3'b000 && depth < CNT_W'(DEPTH)) |=> depth == $past(depth) + CNT_W'(1));

    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && instr_op == 3'b001 && depth == '0) |=> (error && depth == '0));

    // R4
    fold_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && instr_op == 3'b010 && depth >= CNT_W'(2)) |=> depth == $past(depth) - CNT_W'(1));

    // R6
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(DEPTH));

endmodule

bind stack_calc_core stkm_chk #(
    .CNT_W (CNT_W),
    .DEPTH (STACK_DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_op    (instr_op),
    .halted      (halted),
    .error       (error),
    .busy        (busy),
    .depth       (stk_count)
);

// File: tb/tb_stack_calc_core.sv
`timescale 1ns/1ps
module tb_stack_calc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [2:0]  instr_op = 3'b000;
    logic [3:0]  instr_addr = '0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        busy, halted, error;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    stack_calc_core dut (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_op(instr_op), .instr_addr(instr_addr),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .busy(busy), .halted(halted), .error(error)
    );

    // behavioural reference
    logic [15:0] m_stk[$];
    logic [15:0] m_mem [16];
    bit m_halt, m_err, m_busy;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stk.delete();
            foreach (m_mem[i]) m_mem[i] = '0;
            m_halt = 0; m_err = 0; m_busy = 0;
        end else begin
            bit acc, allowed;
            logic [15:0] a, b;
            acc     = instr_valid && !m_halt;
            allowed = m_halt || !instr_valid;
            m_busy  = acc;
            if (host_we && allowed) m_mem[host_addr] = host_wdata;
            if (acc) begin
                case (instr_op)
                    3'b000: if (m_stk.size() >= 8) m_err = 1; else m_stk.push_back(m_mem[instr_addr]);
                    3'b001: if (m_stk.size() == 0) m_err = 1; else m_mem[instr_addr] = m_stk.pop_back();
                    3'b010, 3'b011, 3'b100, 3'b101: begin
                        if (m_stk.size() < 2) m_err = 1;
                        else begin
                            b = m_stk[m_stk.size()-1];
                            a = m_stk[m_stk.size()-2];
                            if (instr_op == 3'b101 && b == 0) m_err = 1;
                            else begin
                                void'(m_stk.pop_back());
                                void'(m_stk.pop_back());
                                case (instr_op)
                                    3'b010: m_stk.push_back(a + b);
                                    3'b011: m_stk.push_back(a - b);
                                    3'b100: m_stk.push_back(a * b);
                                    default: m_stk.push_back(a / b);
                                endcase
                            end
                        end
                    end
                    3'b111: m_halt = 1;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        chk("R8 instr_ready", instr_ready, !m_halt);
        chk("R8 halted", halted, m_halt);
        chk("R6 error", error, m_err);
        chk("R9 busy", busy, m_busy);
        chk("R10 host_rdata", host_rdata, (m_halt || !instr_valid) ? m_mem[host_addr] : 16'h0);
    end

    task automatic do_reset();
        rst_n = 1'b0;
        instr_valid = 1'b0;
        host_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [2:0] op, input logic [3:0] a);
        instr_valid = 1'b1;
        instr_op    = op;
        instr_addr  = a;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [15:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [3:0] a, input logic [15:0] exp, input string tag);
        host_addr = a;
        @(posedge clk); #1;
        chk(tag, host_rdata, exp);
        @(negedge clk);
    endtask

    task automatic preload();
        hwrite(0, 16'd3);  hwrite(1, 16'd4);  hwrite(2, 16'd5);  hwrite(3, 16'd6);
        hwrite(4, 16'd2);  hwrite(5, 16'd3);  hwrite(6, 16'd6);  hwrite(7, 16'd0);
        hwrite(8, 16'hFFFF); hwrite(9, 16'd7); hwrite(10, 16'd2);
    endtask

    localparam logic [2:0] PUSH = 3'b000, POP = 3'b001, ADD = 3'b010, SUB = 3'b011,
                           MUL = 3'b100, DIV = 3'b101, RSV = 3'b110, HALT = 3'b111;

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R11 reset state
        do_reset();
        @(posedge clk); #1;
        chk("R11 ready", instr_ready, 1); chk("R11 halted", halted, 0);
        chk("R11 error", error, 0);       chk("R11 busy", busy, 0);
        @(negedge clk);
        hread(4'd9, 16'd0, "R11 memory cleared");
        preload();

        // R13 (2+3)-6/3
        issue(PUSH, 4); issue(PUSH, 5); issue(ADD, 0);
        issue(PUSH, 6); issue(PUSH, 5); issue(DIV, 0); issue(SUB, 0);
        issue(POP, 11);
        hread(4'd11, 16'd3, "R13 infix result");
        chk("R1 no error", error, 0);
        // R6 stack now empty: pop faults and memory stays
        issue(POP, 12);
        @(posedge clk); #1; chk("R6 pop empty error", error, 1); @(negedge clk);
        hread(4'd12, 16'd0, "R6 faulted pop no write");

        do_reset(); preload();
        // R13 X*Y+W*U
        issue(PUSH, 0); issue(PUSH, 1); issue(MUL, 0);
        issue(PUSH, 2); issue(PUSH, 3); issue(MUL, 0); issue(ADD, 0);
        issue(POP, 12);
        hread(4'd12, 16'd42, "R13 sum of products");
        // R4 subtract order
        issue(PUSH, 6); issue(PUSH, 5); issue(SUB, 0); issue(POP, 13);
        hread(4'd13, 16'd3, "R4 subtract order");
        // R4 add wrap
        issue(PUSH, 8); issue(PUSH, 5); issue(ADD, 0); issue(POP, 14);
        hread(4'd14, 16'd2, "R4 add wrap");
        // R4 multiply wrap
        issue(PUSH, 8); issue(PUSH, 8); issue(MUL, 0); issue(POP, 15);
        hread(4'd15, 16'd1, "R4 multiply wrap");
        // R5 truncation and 6/3
        issue(PUSH, 9); issue(PUSH, 10); issue(DIV, 0); issue(POP, 0);
        hread(4'd0, 16'd3, "R5 7/2 truncates");
        issue(PUSH, 6); issue(PUSH, 5); issue(DIV, 0); issue(POP, 0);
        hread(4'd0, 16'd2, "R5 6/3");
        // R12 reserved opcode
        issue(PUSH, 9); issue(RSV, 4); issue(POP, 1);
        hread(4'd1, 16'd7, "R12 reserved opcode no effect");
        hread(4'd4, 16'd2, "R12 reserved opcode memory untouched");
        chk("R12 no error", error, 0);
        // R10 host write ignored during an offered instruction
        host_we = 1'b1; host_addr = 4'd2; host_wdata = 16'hAAAA;
        issue(PUSH, 2);
        host_we = 1'b0;
        issue(POP, 3);
        hread(4'd2, 16'd5, "R10 host write ignored");
        hread(4'd3, 16'd5, "R2 push copied word");
        // R3 pop moves top
        issue(PUSH, 9); issue(PUSH, 10); issue(POP, 5); issue(POP, 6);
        hread(4'd5, 16'd2, "R3 pop top first");
        hread(4'd6, 16'd7, "R3 pop next");
        // R6 overflow on ninth push
        for (int i = 0; i < 8; i++) issue(PUSH, 9);
        chk("R6 eight fit", error, 0);
        issue(PUSH, 10);
        @(posedge clk); #1; chk("R6 overflow error", error, 1); @(negedge clk);
        issue(POP, 7);
        hread(4'd7, 16'd7, "R6 overflowing push not stored");

        do_reset(); preload();
        // R7 divide by zero
        issue(PUSH, 9); issue(PUSH, 7); issue(DIV, 0);
        @(posedge clk); #1; chk("R7 div zero error", error, 1); @(negedge clk);
        issue(POP, 2); issue(POP, 3);
        hread(4'd2, 16'd0, "R7 divisor kept");
        hread(4'd3, 16'd7, "R7 dividend kept");

        do_reset(); preload();
        // R6 arithmetic with one entry
        issue(PUSH, 9); issue(ADD, 0);
        @(posedge clk); #1; chk("R6 short add error", error, 1); @(negedge clk);
        issue(POP, 2);
        hread(4'd2, 16'd7, "R6 short add no effect");

        do_reset(); preload();
        // R8 halt
        issue(HALT, 0);
        @(posedge clk); #1;
        chk("R8 halted", halted, 1); chk("R8 not ready", instr_ready, 0);
        @(negedge clk);
        instr_valid = 1'b1; instr_op = PUSH; instr_addr = 4'd9;
        repeat (3) @(negedge clk);
        chk("R8 ignored while halted busy", busy, 0);
        // R10 host access allowed while halted even with valid high
        hwrite(4'd5, 16'h1234);
        instr_valid = 1'b0;
        hread(4'd5, 16'h1234, "R10 write while halted");
        do_reset();
        @(posedge clk); #1; chk("R8 ready after reset", instr_ready, 1); @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule